// File: doc/BRIEF.md
# Microprogrammed Accumulator Processor

This block is a small processor with a single accumulator. Its program and data sit together in an internal word memory. A micro-sequencer controls it. A micro-program counter steps through a control store. Each control word enables exactly one source onto a shared internal bus and tells any number of registers to capture that bus. Every instruction runs the same fetch routine and a decode step. The decode step dispatches on the opcode to an execute routine, and the last step of that routine sends the micro-program counter back to zero.

The program is loaded through a write port while reset is held. After reset is released the processor starts at address 0. It runs until it meets a halt instruction. It reads external data through an input port and reports results on an output port, together with a one-cycle valid strobe.

Top module: `acc_cpu`

## Requirements
- R1: An instruction word is 16 bits wide. Bits 15:12 hold the opcode and bits 11:0 hold an operand address. Memory is indexed by the low address bits of that operand. The opcodes are 0 NOP, 1 LDA, 2 STA, 3 ADD, 4 SUB, 5 IN, 6 OUT, 7 JMP, 8 JN, 9 HLT, 0xA CMP, 0xB JG, 0xC JE and 0xD JL.
- R2: Reset clears the program counter, the accumulator, the three compare flags and the micro-program counter. During reset `out_data`, `out_valid` and `halted` read 0. Execution then starts at address 0. The program port writes memory only while reset is high.
- R3: Micro-steps 0 to 3 fetch the instruction and increment the PC once. Step 4 dispatches on the opcode. Execution routines begin at step 5, and each ends by returning to step 0. An HLT at address 0 raises `halted` on the 5th rising edge after reset. A NOP followed by an HLT raises it on the 11th edge.
- R4: In every micro-step at most one source drives the internal bus.
- R5: LDA copies memory[operand] into the accumulator. STA writes the accumulator into memory[operand].
- R6: ADD and SUB replace the accumulator with the accumulator plus or minus memory[operand], modulo 2^16.
- R7: IN loads the accumulator from `in_data`. OUT copies the accumulator to `out_data` and pulses `out_valid` high for exactly one cycle.
- R8: CMP compares the accumulator with memory[operand] as unsigned numbers. It sets exactly one of three flags: greater, equal or less.
- R9: JG, JE and JL load the PC with the operand only when their own flag is set. Otherwise execution continues at the next address.
- R10: JMP always loads the PC with the operand. JN loads it only when bit 15 of the accumulator is 1.
- R11: HLT stops the micro-program counter and holds `halted` at 1 until reset. While halted, no further output is produced.
- R12: Opcodes 0xE and 0xF behave exactly like NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; program loading window |
| prog_we | input | 1 | Program memory write strobe, honoured only during reset |
| prog_addr | input | AW | Program memory write address |
| prog_wdata | input | 16 | Program memory write data |
| in_data | input | 16 | Input port value read by IN |
| out_data | output | 16 | Output port register written by OUT |
| out_valid | output | 1 | One-cycle strobe marking an OUT |
| halted | output | 1 | High once HLT has executed |

## Verification
One fixed test program runs under a sweep of operand pairs and input values. The pairs include zero, one, the sign boundary and the all-ones word. These values separate carry and borrow wraparound in ADD and SUB, the sign test in JN, and all three outcomes of the unsigned CMP, because each outcome selects a different constant to output. A second program runs straight after a reset that interrupts a running program. It shows that the PC, the accumulator and the flags really were cleared: no conditional jump is taken, and the value output is zero. Two tiny programs measure the cycle count at which the processor halts, which pins down the length of the fetch and dispatch sequence.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int WORD_W = 16;
    localparam int OPC_W  = 4;
    localparam int OPD_W  = 12;
    localparam int UPC_W  = 5;

    typedef enum logic [OPC_W-1:0] {
        OP_NOP, OP_LDA, OP_STA, OP_ADD, OP_SUB, OP_IN, OP_OUT, OP_JMP,
        OP_JN, OP_HLT, OP_CMP, OP_JG, OP_JE, OP_JL, OP_RSV0, OP_RSV1
    } opcode_e;

    typedef enum logic [2:0] {
        JC_NONE, JC_ALWAYS, JC_NEG, JC_GT, JC_EQ, JC_LT
    } jcond_e;

    typedef enum logic {
        AOP_ADD, AOP_SUB
    } aop_e;

    // bus sources, one bit each
    typedef struct packed {
        logic pc_rd;
        logic ir_rd;
        logic mem_rd;
        logic acc_rd;
        logic in_rd;
        logic alu_rd;
    } src_t;

    typedef struct packed {
        src_t   src;
        logic   mar_ld;
        logic   ir_ld;
        logic   acc_ld;
        logic   b_ld;
        logic   flag_ld;
        logic   out_ld;
        logic   mem_wr;
        logic   pc_inc;
        jcond_e jmp;
        aop_e   aop;
        logic   dispatch;
        logic   ret;
        logic   halt;
    } cword_t;

    // execute routine entry points in the control store
    localparam logic [UPC_W-1:0] U_DECODE = 5'd4;
    localparam logic [UPC_W-1:0] U_NOP    = 5'd5;
    localparam logic [UPC_W-1:0] U_LDA    = 5'd6;
    localparam logic [UPC_W-1:0] U_STA    = 5'd7;
    localparam logic [UPC_W-1:0] U_ADD    = 5'd8;
    localparam logic [UPC_W-1:0] U_SUB    = 5'd10;
    localparam logic [UPC_W-1:0] U_IN     = 5'd12;
    localparam logic [UPC_W-1:0] U_OUT    = 5'd13;
    localparam logic [UPC_W-1:0] U_JMP    = 5'd14;
    localparam logic [UPC_W-1:0] U_JN     = 5'd15;
    localparam logic [UPC_W-1:0] U_HLT    = 5'd16;
    localparam logic [UPC_W-1:0] U_CMP    = 5'd17;
    localparam logic [UPC_W-1:0] U_JG     = 5'd19;
    localparam logic [UPC_W-1:0] U_JE     = 5'd20;
    localparam logic [UPC_W-1:0] U_JL     = 5'd21;

endpackage

// File: rtl/acc_cpu_ustore.sv
module acc_cpu_ustore
    import acc_cpu_pkg::*;
(
    input  logic [UPC_W-1:0] upc,
    input  logic [OPC_W-1:0] opcode,
    output cword_t           cw,
    output logic [UPC_W-1:0] entry
);

    // control store contents
    always_comb begin
        cw = '0;
        unique case (upc)
            5'd0: begin cw.src.pc_rd = 1'b1; cw.mar_ld = 1'b1; end
            5'd1: begin cw.src.mem_rd = 1'b1; cw.ir_ld = 1'b1; end
            5'd2: begin cw.pc_inc = 1'b1; end
            5'd3: begin cw.src.ir_rd = 1'b1; cw.mar_ld = 1'b1; end
            U_DECODE: begin cw.dispatch = 1'b1; end
            U_NOP: begin cw.ret = 1'b1; end
            U_LDA: begin cw.src.mem_rd = 1'b1; cw.acc_ld = 1'b1; cw.ret = 1'b1; end
            U_STA: begin cw.src.acc_rd = 1'b1; cw.mem_wr = 1'b1; cw.ret = 1'b1; end
            U_ADD: begin cw.src.mem_rd = 1'b1; cw.b_ld = 1'b1; end
            5'd9: begin
                cw.src.alu_rd = 1'b1; cw.aop = AOP_ADD; cw.acc_ld = 1'b1; cw.ret = 1'b1;
            end
            U_SUB: begin cw.src.mem_rd = 1'b1; cw.b_ld = 1'b1; end
            5'd11: begin
                cw.src.alu_rd = 1'b1; cw.aop = AOP_SUB; cw.acc_ld = 1'b1; cw.ret = 1'b1;
            end
            U_IN:  begin cw.src.in_rd = 1'b1; cw.acc_ld = 1'b1; cw.ret = 1'b1; end
            U_OUT: begin cw.src.acc_rd = 1'b1; cw.out_ld = 1'b1; cw.ret = 1'b1; end
            U_JMP: begin cw.src.ir_rd = 1'b1; cw.jmp = JC_ALWAYS; cw.ret = 1'b1; end
            U_JN:  begin cw.src.ir_rd = 1'b1; cw.jmp = JC_NEG; cw.ret = 1'b1; end
            U_HLT: begin cw.halt = 1'b1; end
            U_CMP: begin cw.src.mem_rd = 1'b1; cw.b_ld = 1'b1; end
            5'd18: begin cw.flag_ld = 1'b1; cw.ret = 1'b1; end
            U_JG:  begin cw.src.ir_rd = 1'b1; cw.jmp = JC_GT; cw.ret = 1'b1; end
            U_JE:  begin cw.src.ir_rd = 1'b1; cw.jmp = JC_EQ; cw.ret = 1'b1; end
            U_JL:  begin cw.src.ir_rd = 1'b1; cw.jmp = JC_LT; cw.ret = 1'b1; end
            default: begin cw.ret = 1'b1; end
        endcase
    end

    // opcode dispatch table
    always_comb begin
        unique case (opcode_e'(opcode))
            OP_LDA:  entry = U_LDA;
            OP_STA:  entry = U_STA;
            OP_ADD:  entry = U_ADD;
            OP_SUB:  entry = U_SUB;
            OP_IN:   entry = U_IN;
            OP_OUT:  entry = U_OUT;
            OP_JMP:  entry = U_JMP;
            OP_JN:   entry = U_JN;
            OP_HLT:  entry = U_HLT;
            OP_CMP:  entry = U_CMP;
            OP_JG:   entry = U_JG;
            OP_JE:   entry = U_JE;
            OP_JL:   entry = U_JL;
            default: entry = U_NOP;
        endcase
    end

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  aop_e         op,
    output logic [W-1:0] result,
    output logic         gt,
    output logic         eq,
    output logic         lt
);

    always_comb begin
        result = (op == AOP_SUB) ? (a - b) : (a + b);
        gt     = a > b;
        eq     = a == b;
        lt     = a < b;
    end

endmodule

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem #(
    parameter int DEPTH = 256,
    parameter int W     = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store_q[waddr] <= wdata;
        end
    end

    assign rdata = store_q[raddr];

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int MEM_WORDS = 256,
    localparam int AW       = $clog2(MEM_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_we,
    input  logic [AW-1:0]     prog_addr,
    input  logic [WORD_W-1:0] prog_wdata,
    input  logic [WORD_W-1:0] in_data,
    output logic [WORD_W-1:0] out_data,
    output logic              out_valid,
    output logic              halted
);

    typedef struct packed {
        logic [UPC_W-1:0]  upc;
        logic [OPD_W-1:0]  pc;
        logic [OPD_W-1:0]  mar;
        logic [WORD_W-1:0] ir;
        logic [WORD_W-1:0] acc;
        logic [WORD_W-1:0] b;
        logic              f_gt;
        logic              f_eq;
        logic              f_lt;
        logic [WORD_W-1:0] outr;
        logic              outv;
    } state_t;

    state_t st_q, st_d;

    cword_t            cw;
    logic [UPC_W-1:0]  entry;
    logic [WORD_W-1:0] bus;
    logic [WORD_W-1:0] mem_rdata;
    logic [WORD_W-1:0] alu_res;
    logic              alu_gt, alu_eq, alu_lt;
    logic              jump_taken;
    logic              mem_we;
    logic [AW-1:0]     mem_waddr;
    logic [WORD_W-1:0] mem_wdata;

    acc_cpu_ustore u_ustore (
        .upc    (st_q.upc),
        .opcode (st_q.ir[WORD_W-1 -: OPC_W]),
        .cw     (cw),
        .entry  (entry)
    );

    acc_cpu_alu #(.W(WORD_W)) u_alu (
        .a      (st_q.acc),
        .b      (st_q.b),
        .op     (cw.aop),
        .result (alu_res),
        .gt     (alu_gt),
        .eq     (alu_eq),
        .lt     (alu_lt)
    );

    // loader owns the write port during reset, the datapath afterwards
    always_comb begin
        if (rst) begin
            mem_we    = prog_we;
            mem_waddr = prog_addr;
            mem_wdata = prog_wdata;
        end else begin
            mem_we    = cw.mem_wr;
            mem_waddr = st_q.mar[AW-1:0];
            mem_wdata = bus;
        end
    end

    acc_cpu_mem #(.DEPTH(MEM_WORDS), .W(WORD_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (st_q.mar[AW-1:0]),
        .rdata (mem_rdata)
    );

    // shared internal bus: gated sources, one enabled per micro-step
    always_comb begin
        bus = '0;
        if (cw.src.pc_rd)  bus = bus | {{(WORD_W-OPD_W){1'b0}}, st_q.pc};
        if (cw.src.ir_rd)  bus = bus | {{(WORD_W-OPD_W){1'b0}}, st_q.ir[OPD_W-1:0]};
        if (cw.src.mem_rd) bus = bus | mem_rdata;
        if (cw.src.acc_rd) bus = bus | st_q.acc;
        if (cw.src.in_rd)  bus = bus | in_data;
        if (cw.src.alu_rd) bus = bus | alu_res;
    end

    always_comb begin
        unique case (cw.jmp)
            JC_ALWAYS: jump_taken = 1'b1;
            JC_NEG:    jump_taken = st_q.acc[WORD_W-1];
            JC_GT:     jump_taken = st_q.f_gt;
            JC_EQ:     jump_taken = st_q.f_eq;
            JC_LT:     jump_taken = st_q.f_lt;
            default:   jump_taken = 1'b0;
        endcase
    end

    always_comb begin
        st_d      = st_q;
        st_d.outv = cw.out_ld;
        if (cw.mar_ld)  st_d.mar = bus[OPD_W-1:0];
        if (cw.ir_ld)   st_d.ir  = bus;
        if (cw.acc_ld)  st_d.acc = bus;
        if (cw.b_ld)    st_d.b   = bus;
        if (cw.out_ld)  st_d.outr = bus;
        if (cw.flag_ld) begin
            st_d.f_gt = alu_gt;
            st_d.f_eq = alu_eq;
            st_d.f_lt = alu_lt;
        end
        if (cw.pc_inc)  st_d.pc = st_q.pc + 1'b1;
        if (jump_taken) st_d.pc = bus[OPD_W-1:0];
        if (cw.halt) begin
            st_d.upc = st_q.upc;
        end else if (cw.ret) begin
            st_d.upc = '0;
        end else if (cw.dispatch) begin
            st_d.upc = entry;
        end else begin
            st_d.upc = st_q.upc + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_data  = st_q.outr;
    assign out_valid = st_q.outv;
    assign halted    = cw.halt;

    // views for the bound checker
    logic [UPC_W-1:0] chk_upc;
    logic [OPD_W-1:0] chk_pc;
    logic [5:0]       chk_src;
    logic             chk_pc_inc;
    logic             chk_jump;
    assign chk_upc    = st_q.upc;
    assign chk_pc     = st_q.pc;
    assign chk_src    = cw.src;
    assign chk_pc_inc = cw.pc_inc;
    assign chk_jump   = jump_taken;

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
    import acc_cpu_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [UPC_W-1:0] upc,
    input logic [OPD_W-1:0] pc,
    input logic [5:0]       src,
    input logic             pc_inc,
    input logic             jump,
    input logic             out_valid,
    input logic             halted
);

    a_r3_fetch_steps: assert property (@(posedge clk) disable iff (rst)
        (upc < 5'd4) |=> (upc == UPC_W'($past(upc) + 1'b1)));

    a_r3_dispatch: assert property (@(posedge clk) disable iff (rst)
        (upc == 5'd4) |=> (upc >= 5'd5));

    a_r4_one_source: assert property (@(posedge clk) disable iff (rst)
        $onehot0(src));

    a_r3_pc_hold: assert property (@(posedge clk) disable iff (rst)
        (!pc_inc && !jump) |=> (pc == $past(pc)));

    a_r11_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    a_r7_out_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

endmodule

bind acc_cpu acc_cpu_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .upc       (chk_upc),
    .pc        (chk_pc),
    .src       (chk_src),
    .pc_inc    (chk_pc_inc),
    .jump      (chk_jump),
    .out_valid (out_valid),
    .halted    (halted)
);

// File: tb/sim_acc_cpu.sv
module sim_acc_cpu;

    localparam int CLK_P = 10;
    localparam int AW    = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          prog_we = 1'b0;
    logic [AW-1:0] prog_addr = '0;
    logic [15:0]   prog_wdata = '0;
    logic [15:0]   in_data = '0;
    logic [15:0]   out_data;
    logic          out_valid;
    logic          halted;

    int checks = 0;
    int failures = 0;

    logic [15:0] outs [16];
    int          n_out = 0;

    acc_cpu #(.MEM_WORDS(256)) u0 (
        .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_wdata(prog_wdata), .in_data(in_data), .out_data(out_data),
        .out_valid(out_valid), .halted(halted)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(negedge clk) begin
        if (rst) n_out <= 0;
        else if (out_valid) begin
            if (n_out < 16) outs[n_out] <= out_data;
            n_out <= n_out + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] opd);
        return {op, opd};
    endfunction

    // called with rst high, at a negedge
    task automatic put(input int a, input logic [15:0] w);
        prog_we = 1'b1; prog_addr = AW'(a); prog_wdata = w;
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic enter_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_to_halt();
        int t;
        @(negedge clk);
        rst = 1'b0;
        t = 0;
        while (!halted && t < 3000) begin
            @(negedge clk);
            t++;
        end
        check("R11 reached halt", {31'd0, halted}, 32'd1);
    endtask

    task automatic load_main(input logic [15:0] a, input logic [15:0] b);
        put(0,  ins(4'h5, 12'h000));   // IN
        put(1,  ins(4'h6, 12'h000));   // OUT
        put(2,  ins(4'h3, 12'h040));   // ADD A
        put(3,  ins(4'h6, 12'h000));
        put(4,  ins(4'h4, 12'h041));   // SUB B
        put(5,  ins(4'h6, 12'h000));
        put(6,  ins(4'h2, 12'h042));   // STA tmp
        put(7,  ins(4'h0, 12'h000));
        put(8,  ins(4'h1, 12'h042));   // LDA tmp
        put(9,  ins(4'h6, 12'h000));
        put(10, ins(4'h8, 12'h00D));   // JN 13
        put(11, ins(4'h1, 12'h047));
        put(12, ins(4'h7, 12'h00E));   // JMP 14
        put(13, ins(4'h1, 12'h046));
        put(14, ins(4'h6, 12'h000));
        put(15, ins(4'h1, 12'h040));
        put(16, ins(4'hA, 12'h041));   // CMP B
        put(17, ins(4'hB, 12'h015));   // JG 21
        put(18, ins(4'hC, 12'h017));   // JE 23
        put(19, ins(4'hD, 12'h019));   // JL 25
        put(20, ins(4'h9, 12'h000));
        put(21, ins(4'h1, 12'h043)); put(22, ins(4'h7, 12'h01B));
        put(23, ins(4'h1, 12'h044)); put(24, ins(4'h7, 12'h01B));
        put(25, ins(4'h1, 12'h045)); put(26, ins(4'h7, 12'h01B));
        put(27, ins(4'h6, 12'h000));
        put(28, ins(4'hF, 12'h000));   // reserved opcode
        put(29, ins(4'hE, 12'h000));   // reserved opcode
        put(30, ins(4'h9, 12'h000));   // HLT
        put(31, ins(4'h6, 12'h000));   // must never run
        put(32'h40, a); put(32'h41, b); put(32'h42, 16'h0000);
        put(32'h43, 16'h0001); put(32'h44, 16'h0002); put(32'h45, 16'h0003);
        put(32'h46, 16'h00AA); put(32'h47, 16'h0055);
    endtask

    logic [15:0] vals [6] = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF, 16'h8000, 16'hFFFF};

    initial begin : watchdog
        #(CLK_P * 190000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] sum, diff, cmpv;
        repeat (2) @(negedge clk);
        // R2 reset state
        check("R2 out_data in reset", {16'd0, out_data}, 32'd0);
        check("R2 out_valid in reset", {31'd0, out_valid}, 32'd0);
        check("R2 halted in reset", {31'd0, halted}, 32'd0);

        // R3 timing: HLT at address 0
        put(0, ins(4'h9, 12'h000));
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check("R3 not halted after 4 edges", {31'd0, halted}, 32'd0);
        @(negedge clk);
        check("R3 HLT halts on edge 5", {31'd0, halted}, 32'd1);

        // R3/R12 timing: NOP then HLT, and reserved opcode then HLT
        for (int k = 0; k < 2; k++) begin
            enter_reset();
            put(0, (k == 0) ? ins(4'h0, 12'h000) : ins(4'hE, 12'h000));
            put(1, ins(4'h9, 12'h000));
            rst = 1'b0;
            repeat (10) @(negedge clk);
            check(k == 0 ? "R3 NOP not halted edge 10" : "R12 0xE not halted edge 10",
                  {31'd0, halted}, 32'd0);
            @(negedge clk);
            check(k == 0 ? "R3 NOP halt edge 11" : "R12 0xE halt edge 11",
                  {31'd0, halted}, 32'd1);
        end

        // main sweep
        for (int ia = 0; ia < 6; ia++) begin
            for (int ib = 0; ib < 6; ib++) begin
                for (int ii = 0; ii < 2; ii++) begin
                    enter_reset();
                    load_main(vals[ia], vals[ib]);
                    in_data = (ii == 0) ? 16'h1234 : 16'hFFFE;
                    run_to_halt();
                    sum  = in_data + vals[ia];
                    diff = sum - vals[ib];
                    cmpv = (vals[ia] > vals[ib]) ? 16'd1 :
                           (vals[ia] == vals[ib]) ? 16'd2 : 16'd3;
                    repeat (6) @(negedge clk);
                    check("R11 no output after halt, count", n_out, 32'd6);
                    check("R11 halted sticky", {31'd0, halted}, 32'd1);
                    check("R7 IN/OUT", {16'd0, outs[0]}, {16'd0, in_data});
                    check("R6 ADD", {16'd0, outs[1]}, {16'd0, sum});
                    check("R6 SUB", {16'd0, outs[2]}, {16'd0, diff});
                    check("R5 STA/LDA", {16'd0, outs[3]}, {16'd0, diff});
                    check("R10 JN", {16'd0, outs[4]}, diff[15] ? 32'h00AA : 32'h0055);
                    check("R8 R9 CMP and branch", {16'd0, outs[5]}, {16'd0, cmpv});
                    check("R1 R12 final out_data", {16'd0, out_data}, {16'd0, cmpv});
                end
            end
        end

        // R2: reset in mid-run clears PC, ACC and flags
        enter_reset();
        load_main(16'h0005, 16'h0003);
        in_data = 16'h8001;
        @(negedge clk);
        rst = 1'b0;
        repeat (60) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R2 out_data cleared", {16'd0, out_data}, 32'd0);
        check("R2 halted cleared", {31'd0, halted}, 32'd0);
        put(0, ins(4'hB, 12'h006));    // JG 6
        put(1, ins(4'hC, 12'h006));    // JE 6
        put(2, ins(4'hD, 12'h006));    // JL 6
        put(3, ins(4'h6, 12'h000));    // OUT acc
        put(4, ins(4'h9, 12'h000));
        put(6, ins(4'h5, 12'h000));    // IN
        put(7, ins(4'h6, 12'h000));
        put(8, ins(4'h9, 12'h000));
        run_to_halt();
        @(negedge clk);
        check("R2 R9 one output after reset", n_out, 32'd1);
        check("R2 ACC and flags cleared", {16'd0, outs[0]}, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule